// File: doc/BRIEF.md
# Cascadable 3x3 Pixel Convolver

This block forms a 3x3 two-dimensional convolution over a pixel stream. Three signed 12-bit row inputs carry one column of three vertically adjacent pixels per clock; the rows have already been line-delayed outside the block. The block keeps the three most recent columns as a sliding window, multiplies each of the nine pixels by its own signed 10-bit coefficient, and adds the products. A signed 16-bit cascade input is added at output scale, and the total is rounded half-up and saturated to a signed 16-bit cascade output. Chaining the output of one block into the cascade input of the next builds kernels larger than 3x3. One result leaves the block every clock.

The nine coefficients sit in three banks, one bank per window column age. A 2-bit write code picks a bank, and three 10-bit coefficient buses load one coefficient per row into that bank in one cycle. A window state machine counts how many consecutive valid columns the window holds. Its states are WIN_EMPTY, WIN_ONE, WIN_TWO and WIN_FULL. A valid column moves WIN_EMPTY to WIN_ONE, WIN_ONE to WIN_TWO, WIN_TWO to WIN_FULL, and keeps WIN_FULL in WIN_FULL. A cycle without a valid column returns every state to WIN_EMPTY. The output valid flag follows the WIN_FULL condition through the arithmetic pipeline.

Top module: `conv3_cascade`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` is 0 and `cas_out` is 0.
- R2: Each result is the sum over rows A, B and C of three products. Within a row, the oldest of the three columns uses bank 1, the middle column uses bank 2 and the newest uses bank 3. Row A uses the `coef_a` values, row B `coef_b`, row C `coef_c`.
- R3: If the newest column of a window is accepted at clock edge t, its result appears on `cas_out` after edge t+4. The oldest column is therefore accepted at t-2 and the result appears 6 edges after it.
- R4: The `cas_in` value sampled at edge t+1 is added into the result of R3 with weight 2^8 in the sum of products, which is one LSB of `cas_out`. With all nine window pixels zero, `cas_out` equals that `cas_in` value.
- R5: The result is floor((sum_of_products + cas*256 + 128) / 256), which rounds half up. Examples: a sum of 128 gives 1, -128 gives 0, 384 gives 2 and -384 gives -1.
- R6: A rounded value above 32767 leaves as 32767, and a value below -32768 leaves as -32768.
- R7: On a clock edge where `coef_wr` is 2'b01, the block loads bank 1 from the three coefficient buses. Code 2'b10 loads bank 2 and code 2'b11 loads bank 3.
- R8: Code 2'b00 leaves all nine coefficients unchanged, whatever is on the coefficient buses.
- R9: A coefficient write at edge t applies to every result whose newest column is accepted at edge t or later. Results whose newest column came earlier use the previous value.
- R10: `out_valid` is 1 after edge t+4 exactly when `in_valid` was 1 at edges t-2, t-1 and t. This is the WIN_FULL condition of the window state machine.
- R11: With `in_valid` held high, a new valid result appears on every clock.
- R12: Pixels, coefficients, the cascade input and the cascade output are two's complement, and no intermediate sum overflows before rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The current column on the row inputs is valid |
| pix_a | input | 12 | Row A pixel, signed |
| pix_b | input | 12 | Row B pixel, signed |
| pix_c | input | 12 | Row C pixel, signed |
| cas_in | input | 16 | Cascade input at output scale, signed |
| coef_wr | input | 2 | Coefficient write code: 00 hold, 01/10/11 load bank 1/2/3 |
| coef_a | input | 10 | Row A coefficient for the selected bank, signed |
| coef_b | input | 10 | Row B coefficient for the selected bank, signed |
| coef_c | input | 10 | Row C coefficient for the selected bank, signed |
| cas_out | output | 16 | Rounded, saturated result, signed |
| out_valid | output | 1 | `cas_out` belongs to a window of three valid columns |

## Verification
The bound checker tests, on every cycle, that the outputs are clear just after reset and that `out_valid` never rises during the pipeline fill. It also tests that `out_valid` tracks three consecutive valid columns at the fixed latency, and that a window of zero pixels passes the cascade value through unchanged at its three-cycle offset. Other behaviours depend on which coefficients are loaded, so only the bench's scenarios show them. These are the mapping of banks to column ages, the hold code ignoring its buses, the edge on which a new coefficient takes effect, half-up rounding at exact half values, and clamping at both ends of the range.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

    // Rows in the window (A, B, C) and columns kept per row.
    localparam int ROWS = 3;
    localparam int TAPS = 3;

    // Window fill tracking: number of consecutive valid columns held.
    typedef enum logic [1:0] {
        WIN_EMPTY = 2'd0,
        WIN_ONE   = 2'd1,
        WIN_TWO   = 2'd2,
        WIN_FULL  = 2'd3
    } win_state_e;

    // Coefficient write codes; a non-zero code selects the bank for
    // column age (code - 1), oldest column first.
    typedef enum logic [1:0] {
        WR_HOLD   = 2'b00,
        WR_OLDEST = 2'b01,
        WR_MIDDLE = 2'b10,
        WR_NEWEST = 2'b11
    } coef_wr_e;

endpackage

// File: rtl/conv3_coef_bank.sv
module conv3_coef_bank
    import conv3_pkg::*;
#(
    parameter int COEF_W = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [1:0]                             wr_code,
    input  logic [ROWS-1:0][COEF_W-1:0]            coef_in,
    output logic [ROWS-1:0][TAPS-1:0][COEF_W-1:0]  coef_q
);

    logic [COEF_W-1:0] k_r [ROWS][TAPS];

    for (genvar c = 0; c < TAPS; c++) begin : g_bank
        // Code for this bank: 01 -> oldest column, 11 -> newest column.
        localparam logic [1:0] BANK_CODE = 2'(c + 1);

        for (genvar r = 0; r < ROWS; r++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    k_r[r][c] <= '0;
                end else if (wr_code == BANK_CODE) begin
                    k_r[r][c] <= coef_in[r];
                end
            end

            assign coef_q[r][c] = k_r[r][c];
        end
    end

endmodule

// File: rtl/conv3_window.sv
module conv3_window
    import conv3_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [ROWS-1:0][PIX_W-1:0]            pix,
    output logic [ROWS-1:0][TAPS-1:0][PIX_W-1:0]  win,
    output logic                                  win_full
);

    win_state_e state_q;
    win_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: each valid column advances toward WIN_FULL, any gap
    // empties the window.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_EMPTY: state_d = in_valid ? WIN_ONE  : WIN_EMPTY;
            WIN_ONE:   state_d = in_valid ? WIN_TWO  : WIN_EMPTY;
            WIN_TWO:   state_d = in_valid ? WIN_FULL : WIN_EMPTY;
            WIN_FULL:  state_d = in_valid ? WIN_FULL : WIN_EMPTY;
        endcase
    end

    // Output decode.
    always_comb begin
        win_full = (state_q == WIN_FULL);
    end

    // Column shift registers; index 0 is the oldest column.
    logic [PIX_W-1:0] tap_r [ROWS][TAPS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < TAPS; i++) begin
                    tap_r[r][i] <= '0;
                end
            end else begin
                for (int i = 0; i < TAPS - 1; i++) begin
                    tap_r[r][i] <= tap_r[r][i+1];
                end
                tap_r[r][TAPS-1] <= pix[r];
            end
        end

        for (genvar c = 0; c < TAPS; c++) begin : g_tap
            assign win[r][c] = tap_r[r][c];
        end
    end

endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
    import conv3_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int COEF_W  = 10,
    parameter int CAS_W   = 16,
    parameter int SHIFT   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   win_full,
    input  logic [ROWS-1:0][TAPS-1:0][PIX_W-1:0]   win,
    input  logic [ROWS-1:0][TAPS-1:0][COEF_W-1:0]  coef,
    input  logic [CAS_W-1:0]                       cas_in,
    output logic [CAS_W-1:0]                       cas_out,
    output logic                                   out_valid
);

    localparam int PROD_W  = PIX_W + COEF_W;
    localparam int ROW_W   = PROD_W + $clog2(TAPS);
    localparam int SUM_W   = ROW_W + $clog2(ROWS);
    localparam int CASX_W  = CAS_W + SHIFT + 1;
    localparam int ACC_W   = ((SUM_W > CASX_W) ? SUM_W : CASX_W) + 2;
    localparam int STAGES  = 4;

    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (CAS_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] OUT_MIN = ACC_W'(-(64'sd1 <<< (CAS_W - 1)));
    localparam logic [CAS_W-1:0]        SAT_HI  = {1'b0, {(CAS_W-1){1'b1}}};
    localparam logic [CAS_W-1:0]        SAT_LO  = {1'b1, {(CAS_W-1){1'b0}}};

    // Stage 1: nine products and the cascade sample.
    logic signed [PROD_W-1:0] prod_q [ROWS][TAPS];
    logic signed [CAS_W-1:0]  cas_s1_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_prow
        for (genvar c = 0; c < TAPS; c++) begin : g_pcol
            logic signed [PROD_W-1:0] px;
            logic signed [PROD_W-1:0] kx;
            assign px = PROD_W'($signed(win[r][c]));
            assign kx = PROD_W'($signed(coef[r][c]));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod_q[r][c] <= '0;
                end else begin
                    prod_q[r][c] <= px * kx;
                end
            end
        end
    end

    // Stage 2: row sums and the aligned cascade value.
    logic signed [ROW_W-1:0] row_q [ROWS];
    logic signed [CAS_W-1:0] cas_s2_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_rsum
        logic signed [ROW_W-1:0] row_d;
        always_comb begin
            row_d = '0;
            for (int c = 0; c < TAPS; c++) begin
                row_d = row_d + ROW_W'(prod_q[r][c]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else begin
                row_q[r] <= row_d;
            end
        end
    end

    // Stage 3: total with the cascade value scaled to output weight.
    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        acc_d = ACC_W'(cas_s2_q) <<< SHIFT;
        for (int r = 0; r < ROWS; r++) begin
            acc_d = acc_d + ACC_W'(row_q[r]);
        end
    end

    // Stage 4: half-up rounding and saturation.
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] shr;
    logic        [CAS_W-1:0] sat_d;

    always_comb begin
        rnd = acc_q + HALF;
        shr = rnd >>> SHIFT;
        if (shr > OUT_MAX) begin
            sat_d = SAT_HI;
        end else if (shr < OUT_MIN) begin
            sat_d = SAT_LO;
        end else begin
            sat_d = shr[CAS_W-1:0];
        end
    end

    logic [STAGES-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_s1_q <= '0;
            cas_s2_q <= '0;
            acc_q    <= '0;
            cas_out  <= '0;
            vld_q    <= '0;
        end else begin
            cas_s1_q <= $signed(cas_in);
            cas_s2_q <= cas_s1_q;
            acc_q    <= acc_d;
            cas_out  <= sat_d;
            vld_q    <= {vld_q[STAGES-2:0], win_full};
        end
    end

    assign out_valid = vld_q[STAGES-1];

endmodule

// File: rtl/conv3_cascade.sv
module conv3_cascade
    import conv3_pkg::*;
#(
    parameter int PIX_W       = 12,
    parameter int COEF_W      = 10,
    parameter int CAS_W       = 16,
    parameter int ROUND_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  pix_a,
    input  logic [PIX_W-1:0]  pix_b,
    input  logic [PIX_W-1:0]  pix_c,
    input  logic [CAS_W-1:0]  cas_in,
    input  logic [1:0]        coef_wr,
    input  logic [COEF_W-1:0] coef_a,
    input  logic [COEF_W-1:0] coef_b,
    input  logic [COEF_W-1:0] coef_c,
    output logic [CAS_W-1:0]  cas_out,
    output logic              out_valid
);

    logic [ROWS-1:0][PIX_W-1:0]            pix_rows;
    logic [ROWS-1:0][COEF_W-1:0]           coef_rows;
    logic [ROWS-1:0][TAPS-1:0][PIX_W-1:0]  win;
    logic [ROWS-1:0][TAPS-1:0][COEF_W-1:0] coef_q;
    logic                                  win_full;

    assign pix_rows  = {pix_c, pix_b, pix_a};
    assign coef_rows = {coef_c, coef_b, coef_a};

    conv3_coef_bank #(
        .COEF_W (COEF_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_code (coef_wr),
        .coef_in (coef_rows),
        .coef_q  (coef_q)
    );

    conv3_window #(
        .PIX_W (PIX_W)
    ) window_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .pix      (pix_rows),
        .win      (win),
        .win_full (win_full)
    );

    conv3_mac #(
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W),
        .CAS_W  (CAS_W),
        .SHIFT  (ROUND_SHIFT)
    ) mac_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_full  (win_full),
        .win       (win),
        .coef      (coef_q),
        .cas_in    (cas_in),
        .cas_out   (cas_out),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/conv3_cascade_chk.sv
module conv3_cascade_chk #(
    parameter int PIX_W = 12,
    parameter int CAS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] pix_a,
    input logic [PIX_W-1:0] pix_b,
    input logic [PIX_W-1:0] pix_c,
    input logic [CAS_W-1:0] cas_in,
    input logic [CAS_W-1:0] cas_out,
    input logic             out_valid
);

    // Edges seen since reset release, saturating.
    logic [3:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 4'hF) begin
            since_rst <= since_rst + 4'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4'd1) |-> (!out_valid && cas_out == '0));

    // R10
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 4'd7) |-> !out_valid);

    // R10
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd8) |->
        (out_valid == ($past(in_valid, 5) && $past(in_valid, 6) && $past(in_valid, 7))));

    // R4
    cascade_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd8)
         && $past(pix_a, 5) == '0 && $past(pix_a, 6) == '0 && $past(pix_a, 7) == '0
         && $past(pix_b, 5) == '0 && $past(pix_b, 6) == '0 && $past(pix_b, 7) == '0
         && $past(pix_c, 5) == '0 && $past(pix_c, 6) == '0 && $past(pix_c, 7) == '0)
        |-> (cas_out == $past(cas_in, 4)));

endmodule

bind conv3_cascade conv3_cascade_chk #(
    .PIX_W (PIX_W),
    .CAS_W (CAS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pix_a     (pix_a),
    .pix_b     (pix_b),
    .pix_c     (pix_c),
    .cas_in    (cas_in),
    .cas_out   (cas_out),
    .out_valid (out_valid)
);

// File: tb/conv3_cascade_tb_top.sv
module conv3_cascade_tb_top;

    localparam int PIX_W  = 12;
    localparam int COEF_W = 10;
    localparam int CAS_W  = 16;
    localparam int SHIFT  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [PIX_W-1:0]  pix_a, pix_b, pix_c;
    logic [CAS_W-1:0]  cas_in;
    logic [1:0]        coef_wr;
    logic [COEF_W-1:0] coef_a, coef_b, coef_c;
    logic [CAS_W-1:0]  cas_out;
    logic              out_valid;

    always #5 clk = ~clk;

    conv3_cascade dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pix_a     (pix_a),
        .pix_b     (pix_b),
        .pix_c     (pix_c),
        .cas_in    (cas_in),
        .coef_wr   (coef_wr),
        .coef_a    (coef_a),
        .coef_b    (coef_b),
        .coef_c    (coef_c),
        .cas_out   (cas_out),
        .out_valid (out_valid)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    cyc;
        int    val;
        string tag;
    } exp_t;

    exp_t  sbq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    seed  = 32'h1234_5678;

    int     km [3][3];
    bit     hv [int];
    int     hp [int][3];
    longint ps [int];
    string  ht [int];

    function automatic bit vld(int e);
        return hv.exists(e) ? hv[e] : 1'b0;
    endfunction

    // Expected output from the requirements: half-up rounding, saturation.
    function automatic int expect_out(longint acc);
        longint r;
        r = (acc + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int rnd(int lo, int hi);
        seed = seed * 1103515245 + 12345;
        return lo + int'((unsigned'(seed) >> 8) % unsigned'(hi - lo + 1));
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver: applies one column and records the scoreboard model.
    task automatic drive(bit v, int a, int b, int c, int s,
                         logic [1:0] wr, int ka, int kb, int kc, string tag);
        int e;
        @(negedge clk);
        in_valid = v;
        pix_a    = a[PIX_W-1:0];
        pix_b    = b[PIX_W-1:0];
        pix_c    = c[PIX_W-1:0];
        cas_in   = s[CAS_W-1:0];
        coef_wr  = wr;
        coef_a   = ka[COEF_W-1:0];
        coef_b   = kb[COEF_W-1:0];
        coef_c   = kc[COEF_W-1:0];
        e = cyc + 1;
        // R7 R8: only a non-zero code changes a bank.
        if (wr != 2'b00) begin
            km[0][int'(wr) - 1] = ka;
            km[1][int'(wr) - 1] = kb;
            km[2][int'(wr) - 1] = kc;
        end
        hv[e]    = v;
        hp[e][0] = a;
        hp[e][1] = b;
        hp[e][2] = c;
        ht[e]    = tag;
        // R2 R9: products for newest column e use banks after edge e.
        if (v && vld(e - 1) && vld(e - 2)) begin
            longint acc = 0;
            for (int r = 0; r < 3; r++) begin
                for (int age = 0; age < 3; age++) begin
                    acc += longint'(hp[e - 2 + age][r]) * longint'(km[r][age]);
                end
            end
            ps[e] = acc;
        end
        // R3 R4: window whose newest column is e-1 takes cascade at e.
        if (vld(e - 1) && vld(e - 2) && vld(e - 3)) begin
            exp_t it;
            it.cyc = (e - 1) + 4;
            it.val = expect_out(ps[e - 1] + (longint'(s) <<< SHIFT));
            it.tag = ht[e - 1];
            sbq.push_back(it);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R10");
    endtask

    task automatic load(logic [1:0] wr, int ka, int kb, int kc);
        drive(1'b0, 0, 0, 0, 0, wr, ka, kb, kc, "R7");
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (sbq.size() > 0 && sbq[0].cyc < cyc) begin
                n_chk++;
                n_bad++;
                $display("FAIL %s: result due at cycle %0d missing, out_valid=0 expected 1",
                         sbq[0].tag, sbq[0].cyc);
                void'(sbq.pop_front());
            end
            if (out_valid) begin
                n_chk++;
                if (sbq.size() == 0 || sbq[0].cyc != cyc) begin
                    n_bad++;
                    $display("FAIL R10: unexpected out_valid at cycle %0d, actual 1 expected 0", cyc);
                end else begin
                    if (int'($signed(cas_out)) != sbq[0].val) begin
                        n_bad++;
                        $display("FAIL %s: cycle %0d cas_out=%0d expected %0d",
                                 sbq[0].tag, cyc, int'($signed(cas_out)), sbq[0].val);
                    end
                    void'(sbq.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run still busy at cycle %0d, expected finished", cyc);
        finish_run();
    end

    initial begin
        for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) km[r][c] = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        pix_a = '0; pix_b = '0; pix_c = '0;
        cas_in = '0; coef_wr = 2'b00;
        coef_a = '0; coef_b = '0; coef_c = '0;
        repeat (3) @(negedge clk);

        // R1: outputs clear while in reset.
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%b expected 0", out_valid);
        end
        n_chk++;
        if (cas_out !== '0) begin
            n_bad++;
            $display("FAIL R1: cas_out=%0d expected 0", cas_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R7: load distinct banks (1 = oldest, 3 = newest).
        load(2'b01, 3, -11, 19);
        load(2'b10, 5, 13, -23);
        load(2'b11, 7, -17, 29);

        // R2: impulse of 256 on each row exposes KA/KB/KC per column age.
        for (int row = 0; row < 3; row++) begin
            for (int i = 0; i < 7; i++) begin
                int p = (i == 2) ? 256 : 0;
                drive(1'b1, row == 0 ? p : 0, row == 1 ? p : 0, row == 2 ? p : 0,
                      0, 2'b00, 0, 0, 0, "R2 R3 R7");
            end
            idle(1);
        end

        // R4: zero pixels, varying cascade.
        for (int i = 0; i < 8; i++)
            drive(1'b1, 0, 0, 0, rnd(-32768, 32767), 2'b00, 0, 0, 0, "R4");
        idle(1);

        // R11 R12: continuous signed stream with cascade.
        for (int i = 0; i < 40; i++)
            drive(1'b1, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-2048, 2047),
                  rnd(-3000, 3000), 2'b00, 0, 0, 0, "R11 R12");

        // R10: gaps in the valid stream.
        for (int i = 0; i < 30; i++)
            drive((i % 5) != 3 && (i % 11) != 7, rnd(-500, 500), rnd(-500, 500),
                  rnd(-500, 500), rnd(-100, 100), 2'b00, 0, 0, 0, "R10");
        idle(1);

        // R8: hold code with noise on the coefficient buses.
        for (int i = 0; i < 12; i++)
            drive(1'b1, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-2048, 2047), 0,
                  2'b00, rnd(-512, 511), rnd(-512, 511), rnd(-512, 511), "R8");

        // R9: bank writes mid-stream, each taking effect at its own edge.
        for (int i = 0; i < 14; i++) begin
            logic [1:0] wr;
            wr = (i == 4) ? 2'b10 : (i == 9) ? 2'b01 : 2'b00;
            drive(1'b1, rnd(-1000, 1000), rnd(-1000, 1000), rnd(-1000, 1000), 0,
                  wr, rnd(-512, 511), rnd(-512, 511), rnd(-512, 511), "R9 R7");
        end
        idle(1);

        // R5: exact half values, single coefficient 1 on KA3.
        load(2'b01, 0, 0, 0);
        load(2'b10, 0, 0, 0);
        load(2'b11, 1, 0, 0);
        begin
            int hv5 [8] = '{128, -128, 384, -384, 127, -129, 640, -640};
            for (int i = 0; i < 8; i++)
                drive(1'b1, hv5[i], 0, 0, 0, 2'b00, 0, 0, 0, "R5");
        end
        idle(1);

        // R6: saturation at both ends.
        load(2'b01, 511, 511, 511);
        load(2'b10, 511, 511, 511);
        load(2'b11, 511, 511, 511);
        for (int i = 0; i < 5; i++)
            drive(1'b1, 2047, 2047, 2047, 30000, 2'b00, 0, 0, 0, "R6");
        for (int i = 0; i < 5; i++)
            drive(1'b1, -2048, -2048, -2048, -30000, 2'b00, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++)
            drive(1'b1, 20, -20, 10, 32767, 2'b00, 0, 0, 0, "R6 R4");

        idle(10);
        repeat (3) @(negedge clk);

        // R3: every expected result was produced.
        n_chk++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R3: %0d results outstanding, expected 0", sbq.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule